// File: doc/BRIEF.md
# Platform Power State Sequencer

This controller moves a processor platform between its power states: fully off, soft-off, suspended and running. It raises and drops the main rail enable, watches the standby and main power-good inputs and the two sleep-state strobes from the SoC, and passes qualified power-good levels back to the SoC. Each move between stable states goes through a transitional state. The transitional state pulses a one-cycle event strobe and sets the wireless-state output. These strobes let surrounding logic run its startup, resume, suspend and shutdown work.

Three request inputs add platform services. The first is a warm-reset pulse of fixed length in milliseconds. The second is a forced-shutdown power-button request, which stays asserted until the SoC reaches soft-off. The third is a throttle level, which passes to the SoC only while the platform is running. A millisecond tick input times every delay. The four platform inputs are asynchronous and each passes through a two-flop synchronizer. The request inputs are synchronous to the clock.

Top module: `pwr_seq_top`

## Requirements
- R1: While reset is held, the outputs are railEn=0, rsmRstN=0, socPwrOk=0, sysRstN=1, pwrBtnReq=0, wireless=0, no event pulses, throttleOut at its idle level, and pwrState=15 (boot). Three clocks after reset is released, the block leaves boot. It goes to S0 (code 6) with railEn=1 when warmStart is high and main power-good is high; otherwise it goes to G3 (code 0) with railEn=0.
- R2: In G3 the state changes only when pwrOnReq is seen high at a clock edge. That edge moves the state to G3toS5 (code 1), and railEn rises one clock later.
- R3: In G3toS5 the block waits for standby power-good and then enters S5 (code 2). If TMO_MS millisecond ticks pass without standby power-good, it drops railEn and returns to G3.
- R4: The state codes are S5toS3=3, S3=4, S3toS0=5, S0toS3=7, S3toS5=8 and S5toG3=9. From S5, a high slpS5n leads to S5toS3 and then S3. From S3, a high slpS3n leads to S3toS0 and then S0; otherwise, a low slpS5n leads to S3toS5 and then S5. From S0, a low slpS3n leads to S0toS3 and then S3. Every transitional state except G3toS5 lasts exactly one clock.
- R5: In S5, S5toS3, S3, S3toS0 or S0, loss of standby power-good moves the state to S5toG3. It then moves to G3 on the next clock, and railEn is 0 from then on.
- R6: Each transitional state gives one single-cycle pulse, in the clock after it: evStartup after S5toS3, evResume after S3toS0, evSuspend after S0toS3, and evShutdown after S3toS5. At most one event is high at a time.
- R7: The wireless output is 2 (on) after S3toS0, 1 (suspended) after S0toS3, and 0 (off) after S3toS5 and after reset.
- R8: rsmRstN equals standby power-good with a latency of three clocks.
- R9: socPwrOk is high only while standby and main power-good are both high. It rises on the (POK_DLY_MS+1)-th millisecond tick after both are seen high, and it falls three clocks after either one drops.
- R10: A warmRstReq seen in any state other than boot, G3 or S5 drives sysRstN low on that edge. sysRstN goes high again on the RST_MS-th millisecond tick after that. A request in boot, G3 or S5, or while sysRstN is already low, has no effect.
- R11: A forceOffReq seen in any state other than boot, G3 or S5 sets pwrBtnReq on that edge. pwrBtnReq stays set until the clock after the state is S5 or G3.
- R12: In S0, throttleOut takes throttleReq XOR THR_ACTIVE_LOW at each edge. In every other state it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-cycle pulse each millisecond |
| pwrOnReq | input | 1 | Request to leave G3 |
| warmStart | input | 1 | Restart with the platform possibly already running |
| stbyGood | input | 1 | Standby power-good, asynchronous |
| mainGood | input | 1 | Main power-good, asynchronous |
| slpS5n | input | 1 | Active-low soft-off sleep strobe from SoC, asynchronous |
| slpS3n | input | 1 | Active-low suspend sleep strobe from SoC, asynchronous |
| warmRstReq | input | 1 | Warm-reset request |
| forceOffReq | input | 1 | Forced-shutdown request |
| throttleReq | input | 1 | Throttle level request |
| railEn | output | 1 | Main rail enable |
| rsmRstN | output | 1 | Active-low resume reset to SoC |
| socPwrOk | output | 1 | Qualified, delayed power-OK to SoC |
| sysRstN | output | 1 | Active-low warm system reset |
| pwrBtnReq | output | 1 | Power-button press to SoC |
| wireless | output | 2 | Wireless state: 0 off, 1 suspended, 2 on |
| evStartup | output | 1 | Startup event pulse |
| evResume | output | 1 | Resume event pulse |
| evSuspend | output | 1 | Suspend event pulse |
| evShutdown | output | 1 | Shutdown event pulse |
| throttleOut | output | 1 | Throttle output to SoC |
| pwrState | output | 4 | Current state code |

## Verification
A change on a platform input reaches the synchronized copy after two edges. It moves the state on the third edge, and the event and wireless outputs follow one edge after the transitional state. The bench drives each input at a falling edge and checks the transitional state after exactly three edges, then the stable state and the event pulse one edge later. Request inputs act on the first edge: sysRstN, pwrBtnReq and throttleOut are checked one edge after the request. The millisecond delays depend on where the tick falls, so the warm-reset width, the power-good rise and the G3toS5 timeout are measured in cycles and checked against a window one tick period wide.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [3:0] {
    ST_G3   = 4'd0,
    ST_G3S5 = 4'd1,
    ST_S5   = 4'd2,
    ST_S5S3 = 4'd3,
    ST_S3   = 4'd4,
    ST_S3S0 = 4'd5,
    ST_S0   = 4'd6,
    ST_S0S3 = 4'd7,
    ST_S3S5 = 4'd8,
    ST_S5G3 = 4'd9,
    ST_BOOT = 4'd15
  } pwrState_e;

  localparam logic [1:0] WL_OFF  = 2'd0;
  localparam logic [1:0] WL_SUSP = 2'd1;
  localparam logic [1:0] WL_ON   = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic railSet;
    logic railClr;
    logic tmoRun;
    logic evStart;
    logic evResume;
    logic evSuspend;
    logic evShutdown;
    logic wlOn;
    logic wlSusp;
    logic wlOff;
    logic inS0;
    logic reqOk;
    logic btnRelease;
  } ctlStrobe_t;

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrOnReq,
  input  logic       warmStart,
  input  logic       stbyOk,
  input  logic       mainOk,
  input  logic       slpS5n,
  input  logic       slpS3n,
  input  logic       tmoHit,
  output pwrState_e  stateQ,
  output ctlStrobe_t ctl
);

  localparam int BW = $clog2(SYNC_STAGES + 1);

  logic [BW-1:0] bootCnt;
  logic          bootDone;
  pwrState_e     stateD;

  assign bootDone = (bootCnt == BW'(SYNC_STAGES));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_BOOT;
      bootCnt <= '0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_BOOT && !bootDone) bootCnt <= bootCnt + BW'(1);
    end
  end

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    ctl.inS0       = (stateQ == ST_S0);
    ctl.reqOk      = !(stateQ inside {ST_BOOT, ST_G3, ST_S5});
    ctl.btnRelease = (stateQ == ST_S5) || (stateQ == ST_G3);
    unique case (stateQ)
      ST_BOOT: if (bootDone) begin
        if (warmStart && mainOk) begin
          stateD = ST_S0;
          ctl.railSet = 1'b1;
        end else begin
          stateD = ST_G3;
          ctl.railClr = 1'b1;
        end
      end
      ST_G3: if (pwrOnReq) stateD = ST_G3S5;
      ST_G3S5: begin
        ctl.tmoRun = 1'b1;
        if (stbyOk) begin
          stateD = ST_S5;
          ctl.railSet = 1'b1;
        end else if (tmoHit) begin
          stateD = ST_G3;
          ctl.railClr = 1'b1;
        end else begin
          ctl.railSet = 1'b1;
        end
      end
      ST_S5: begin
        if (!stbyOk)     stateD = ST_S5G3;
        else if (slpS5n) stateD = ST_S5S3;
      end
      ST_S5S3: begin
        if (!stbyOk) stateD = ST_S5G3;
        else begin
          stateD = ST_S3;
          ctl.evStart = 1'b1;
        end
      end
      ST_S3: begin
        if (!stbyOk)      stateD = ST_S5G3;
        else if (slpS3n)  stateD = ST_S3S0;
        else if (!slpS5n) stateD = ST_S3S5;
      end
      ST_S3S0: begin
        if (!stbyOk) stateD = ST_S5G3;
        else begin
          stateD = ST_S0;
          ctl.evResume = 1'b1;
          ctl.wlOn     = 1'b1;
        end
      end
      ST_S0: begin
        if (!stbyOk)      stateD = ST_S5G3;
        else if (!slpS3n) stateD = ST_S0S3;
      end
      ST_S0S3: begin
        stateD = ST_S3;
        ctl.evSuspend = 1'b1;
        ctl.wlSusp    = 1'b1;
      end
      ST_S3S5: begin
        stateD = ST_S5;
        ctl.evShutdown = 1'b1;
        ctl.wlOff      = 1'b1;
      end
      ST_S5G3: begin
        stateD = ST_G3;
        ctl.railClr = 1'b1;
      end
      default: stateD = ST_G3;
    endcase
  end

endmodule

// File: rtl/pwr_seq_dpath.sv
module pwr_seq_dpath
  import pwr_seq_pkg::*;
#(
  parameter int TMO_MS         = 100,
  parameter int POK_DLY_MS     = 1,
  parameter int RST_MS         = 32,
  parameter bit THR_ACTIVE_LOW = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  ctlStrobe_t ctl,
  input  logic       stbyOk,
  input  logic       mainOk,
  input  logic       warmRstReq,
  input  logic       forceOffReq,
  input  logic       throttleReq,
  output logic       tmoHit,
  output logic       railEn,
  output logic       rsmRstN,
  output logic       socPwrOk,
  output logic       sysRstN,
  output logic       pwrBtnReq,
  output logic [1:0] wireless,
  output logic       evStartup,
  output logic       evResume,
  output logic       evSuspend,
  output logic       evShutdown,
  output logic       throttleOut
);

  localparam int TW = $clog2(TMO_MS + 1);
  localparam int PW = $clog2(POK_DLY_MS + 1);
  localparam int RW = $clog2(RST_MS + 1);
  localparam logic [RW-1:0] RST_LAST = RW'(RST_MS - 1);

  logic [TW-1:0] tmoCnt;
  logic [PW-1:0] pokCnt;
  logic [RW-1:0] rstCnt;
  logic          pokQual;

  assign tmoHit  = (tmoCnt == TW'(TMO_MS));
  assign pokQual = stbyOk && mainOk;

  // rail enable, events, wireless
  always_ff @(posedge clk) begin
    if (!rstN) begin
      railEn     <= 1'b0;
      evStartup  <= 1'b0;
      evResume   <= 1'b0;
      evSuspend  <= 1'b0;
      evShutdown <= 1'b0;
      wireless   <= WL_OFF;
    end else begin
      if (ctl.railSet)      railEn <= 1'b1;
      else if (ctl.railClr) railEn <= 1'b0;
      evStartup  <= ctl.evStart;
      evResume   <= ctl.evResume;
      evSuspend  <= ctl.evSuspend;
      evShutdown <= ctl.evShutdown;
      if (ctl.wlOn)        wireless <= WL_ON;
      else if (ctl.wlSusp) wireless <= WL_SUSP;
      else if (ctl.wlOff)  wireless <= WL_OFF;
    end
  end

  // power-good relay and G3toS5 timeout
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rsmRstN  <= 1'b0;
      socPwrOk <= 1'b0;
      pokCnt   <= '0;
      tmoCnt   <= '0;
    end else begin
      rsmRstN <= stbyOk;
      if (!pokQual) begin
        socPwrOk <= 1'b0;
        pokCnt   <= '0;
      end else if (!socPwrOk && msTick) begin
        if (pokCnt == PW'(POK_DLY_MS)) socPwrOk <= 1'b1;
        else                           pokCnt   <= pokCnt + PW'(1);
      end
      if (!ctl.tmoRun)             tmoCnt <= '0;
      else if (msTick && !tmoHit)  tmoCnt <= tmoCnt + TW'(1);
    end
  end

  // warm reset, forced shutdown, throttle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sysRstN     <= 1'b1;
      rstCnt      <= '0;
      pwrBtnReq   <= 1'b0;
      throttleOut <= THR_ACTIVE_LOW;
    end else begin
      if (sysRstN) begin
        if (ctl.reqOk && warmRstReq) begin
          sysRstN <= 1'b0;
          rstCnt  <= '0;
        end
      end else if (msTick) begin
        if (rstCnt == RST_LAST) sysRstN <= 1'b1;
        else                    rstCnt  <= rstCnt + RW'(1);
      end
      if (ctl.btnRelease)                pwrBtnReq <= 1'b0;
      else if (ctl.reqOk && forceOffReq) pwrBtnReq <= 1'b1;
      if (ctl.inS0) throttleOut <= throttleReq ^ THR_ACTIVE_LOW;
    end
  end

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int TMO_MS         = 100,
  parameter int POK_DLY_MS     = 1,
  parameter int RST_MS         = 32,
  parameter bit THR_ACTIVE_LOW = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       pwrOnReq,
  input  logic       warmStart,
  input  logic       stbyGood,
  input  logic       mainGood,
  input  logic       slpS5n,
  input  logic       slpS3n,
  input  logic       warmRstReq,
  input  logic       forceOffReq,
  input  logic       throttleReq,
  output logic       railEn,
  output logic       rsmRstN,
  output logic       socPwrOk,
  output logic       sysRstN,
  output logic       pwrBtnReq,
  output logic [1:0] wireless,
  output logic       evStartup,
  output logic       evResume,
  output logic       evSuspend,
  output logic       evShutdown,
  output logic       throttleOut,
  output logic [3:0] pwrState
);

  logic [3:0] syncOut;
  logic       stbyS, mainS, slpS5S, slpS3S, tmoHit;
  pwrState_e  stateQ;
  ctlStrobe_t ctl;

  pwr_seq_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN),
    .din({slpS3n, slpS5n, mainGood, stbyGood}),
    .dout(syncOut)
  );
  assign {slpS3S, slpS5S, mainS, stbyS} = syncOut;

  pwr_seq_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .pwrOnReq(pwrOnReq), .warmStart(warmStart),
    .stbyOk(stbyS), .mainOk(mainS), .slpS5n(slpS5S), .slpS3n(slpS3S),
    .tmoHit(tmoHit), .stateQ(stateQ), .ctl(ctl)
  );

  pwr_seq_dpath #(
    .TMO_MS(TMO_MS), .POK_DLY_MS(POK_DLY_MS), .RST_MS(RST_MS),
    .THR_ACTIVE_LOW(THR_ACTIVE_LOW)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .msTick(msTick), .ctl(ctl),
    .stbyOk(stbyS), .mainOk(mainS), .warmRstReq(warmRstReq),
    .forceOffReq(forceOffReq), .throttleReq(throttleReq), .tmoHit(tmoHit),
    .railEn(railEn), .rsmRstN(rsmRstN), .socPwrOk(socPwrOk), .sysRstN(sysRstN),
    .pwrBtnReq(pwrBtnReq), .wireless(wireless), .evStartup(evStartup),
    .evResume(evResume), .evSuspend(evSuspend), .evShutdown(evShutdown),
    .throttleOut(throttleOut)
  );

  assign pwrState = stateQ;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
  import pwr_seq_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [3:0] stateQ,
  input logic       stbyS,
  input logic       mainS,
  input logic       pwrOnReq,
  input logic       railEn,
  input logic [3:0] evVec,
  input logic       socPwrOk,
  input logic       warmRstReq,
  input logic       sysRstN,
  input logic       pwrBtnReq,
  input logic       throttleOut,
  input logic [1:0] wireless
);

  p_g3_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_G3 && !pwrOnReq) |=> (stateQ == ST_G3));

  p_trans_one_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ inside {ST_S5S3, ST_S3S0, ST_S0S3, ST_S3S5, ST_S5G3})
      |=> (stateQ != $past(stateQ)));

  p_stby_loss_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_S0 || stateQ == ST_S3 || stateQ == ST_S5) && !stbyS)
      |=> (stateQ == ST_S5G3));

  p_rail_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_S5G3) |=> !railEn);

  p_ev_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(evVec));

  p_wl_on_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_S3S0 && stbyS) |=> (wireless == WL_ON));

  p_pok_qual_r9: assert property (@(posedge clk) disable iff (!rstN)
    socPwrOk |-> $past(stbyS && mainS));

  p_warm_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_G3 || stateQ == ST_S5) && warmRstReq && sysRstN) |=> sysRstN);

  p_btn_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_S5) |=> !pwrBtnReq);

  p_thr_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_S0) |=> $stable(throttleOut));

endmodule

bind pwr_seq_top pwr_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .stateQ(pwrState), .stbyS(stbyS), .mainS(mainS),
  .pwrOnReq(pwrOnReq), .railEn(railEn),
  .evVec({evShutdown, evSuspend, evResume, evStartup}),
  .socPwrOk(socPwrOk), .warmRstReq(warmRstReq), .sysRstN(sysRstN),
  .pwrBtnReq(pwrBtnReq), .throttleOut(throttleOut), .wireless(wireless)
);

// File: tb/pwr_seq_top_tb_top.sv
module pwr_seq_top_tb_top;

  localparam int  DIV    = 4;
  localparam int  TMO    = 100;
  localparam int  RSTW   = 32;
  localparam int  PDLY   = 1;
  localparam bit  THR_AL = 1'b0;

  localparam int S_G3 = 0, S_G3S5 = 1, S_S5 = 2, S_S5S3 = 3, S_S3 = 4, S_S3S0 = 5,
                 S_S0 = 6, S_S0S3 = 7, S_S3S5 = 8, S_S5G3 = 9, S_BOOT = 15;

  logic clk = 1'b0;
  logic rstN, msTick, pwrOnReq, warmStart, stbyGood, mainGood, slpS5n, slpS3n;
  logic warmRstReq, forceOffReq, throttleReq;
  logic railEn, rsmRstN, socPwrOk, sysRstN, pwrBtnReq, throttleOut;
  logic evStartup, evResume, evSuspend, evShutdown;
  logic [1:0] wireless;
  logic [3:0] pwrState;
  logic [3:0] evs;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  int divCnt = 0;

  assign evs = {evShutdown, evSuspend, evResume, evStartup};

  always #4 clk = ~clk;

  pwr_seq_top dut_i (
    .clk(clk), .rstN(rstN), .msTick(msTick), .pwrOnReq(pwrOnReq),
    .warmStart(warmStart), .stbyGood(stbyGood), .mainGood(mainGood),
    .slpS5n(slpS5n), .slpS3n(slpS3n), .warmRstReq(warmRstReq),
    .forceOffReq(forceOffReq), .throttleReq(throttleReq), .railEn(railEn),
    .rsmRstN(rsmRstN), .socPwrOk(socPwrOk), .sysRstN(sysRstN),
    .pwrBtnReq(pwrBtnReq), .wireless(wireless), .evStartup(evStartup),
    .evResume(evResume), .evSuspend(evSuspend), .evShutdown(evShutdown),
    .throttleOut(throttleOut), .pwrState(pwrState)
  );

  // millisecond tick, one clock every DIV clocks
  initial begin
    msTick = 1'b0;
    forever begin
      @(negedge clk);
      divCnt = (divCnt == DIV - 1) ? 0 : divCnt + 1;
      msTick = (divCnt == 0);
    end
  end

  function automatic logic expThr(input logic r);
    return r ^ THR_AL;
  endfunction

  function automatic logic [3:0] evCode(input int idx);
    return 4'(1 << idx);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chkRange(input string req, input string what, input int act,
                          input int lo, input int hi);
    tests++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // call right after driving an input at a falling edge
  task automatic walk(input int trans, input int stable, input int evIdx, input string req);
    step(3);
    chk(req, "transitional state", int'(pwrState), trans);
    chk("R6", "no event during transition", int'(evs), 0);
    step(1);
    chk(req, "stable state", int'(pwrState), stable);
    chk("R6", "event pulse", int'(evs), int'(evCode(evIdx)));
    step(1);
    chk("R6", "event pulse ends", int'(evs), 0);
  endtask

  task automatic doReset(input logic ws, input logic sg, input logic mg,
                         input int expState, input int expRail);
    int n;
    @(negedge clk);
    rstN = 1'b0; warmStart = ws; stbyGood = sg; mainGood = mg;
    step(3);
    chk("R1", "reset railEn", int'(railEn), 0);
    chk("R1", "reset rsmRstN", int'(rsmRstN), 0);
    chk("R1", "reset socPwrOk", int'(socPwrOk), 0);
    chk("R1", "reset sysRstN", int'(sysRstN), 1);
    chk("R1", "reset pwrBtnReq", int'(pwrBtnReq), 0);
    chk("R7", "reset wireless", int'(wireless), 0);
    chk("R1", "reset events", int'(evs), 0);
    chk("R1", "reset throttle", int'(throttleOut), int'(THR_AL));
    chk("R1", "reset state", int'(pwrState), S_BOOT);
    @(negedge clk);
    rstN = 1'b1;
    n = 0;
    while (pwrState == 4'(S_BOOT) && n < 10) begin
      step(1);
      n++;
    end
    chk("R1", "boot cycles", n, 3);
    chk("R1", "boot target state", int'(pwrState), expState);
    chk("R1", "boot railEn", int'(railEn), expRail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int first, n, w;
    logic r, hold;
    r = 1'($urandom(32'h2b1d));
    rstN = 1'b0; pwrOnReq = 1'b0; warmStart = 1'b0; stbyGood = 1'b0; mainGood = 1'b0;
    slpS5n = 1'b0; slpS3n = 1'b0; warmRstReq = 1'b0; forceOffReq = 1'b0; throttleReq = 1'b0;

    doReset(1'b0, 1'b0, 1'b0, S_G3, 0);

    // R2: G3 holds without a request
    step(6);
    chk("R2", "G3 holds", int'(pwrState), S_G3);
    // R9: main good without standby does not qualify
    @(negedge clk); mainGood = 1'b1;
    step(20);
    chk("R9", "no power-OK without standby", int'(socPwrOk), 0);

    // R2/R3: leave G3, then time out
    @(negedge clk); pwrOnReq = 1'b1;
    step(1);
    chk("R2", "enter G3toS5", int'(pwrState), S_G3S5);
    @(negedge clk); pwrOnReq = 1'b0;
    step(1);
    chk("R2", "rail enable rises", int'(railEn), 1);
    n = 1;
    while (pwrState == 4'(S_G3S5) && n < 600) begin
      step(1);
      n++;
    end
    chkRange("R3", "timeout length", n, (TMO - 1) * DIV + 2, TMO * DIV + 1);
    chk("R3", "timeout returns to G3", int'(pwrState), S_G3);
    chk("R3", "timeout drops rail", int'(railEn), 0);

    // R3/R8/R9: power up with standby good
    @(negedge clk); pwrOnReq = 1'b1;
    step(1);
    @(negedge clk); pwrOnReq = 1'b0; stbyGood = 1'b1;
    first = 0;
    for (int c = 1; c <= 14; c++) begin
      step(1);
      if (c == 3) begin
        chk("R3", "standby good enters S5", int'(pwrState), S_S5);
        chk("R8", "resume reset follows standby", int'(rsmRstN), 1);
      end
      if (c == 2) chk("R8", "resume reset latency", int'(rsmRstN), 0);
      if (socPwrOk && first == 0) first = c;
    end
    chkRange("R9", "power-OK rise delay", first, 2 + PDLY * DIV + 1, 2 + (PDLY + 1) * DIV);

    // R10/R11: requests ignored in S5
    @(negedge clk); warmRstReq = 1'b1; forceOffReq = 1'b1;
    step(1);
    @(negedge clk); warmRstReq = 1'b0; forceOffReq = 1'b0;
    step(3);
    chk("R10", "warm reset ignored in S5", int'(sysRstN), 1);
    chk("R11", "force off ignored in S5", int'(pwrBtnReq), 0);

    // R4/R6/R7: walk up
    @(negedge clk); slpS5n = 1'b1;
    walk(S_S5S3, S_S3, 0, "R4");
    chk("R7", "wireless still off", int'(wireless), 0);
    @(negedge clk); slpS3n = 1'b1;
    walk(S_S3S0, S_S0, 1, "R4");
    chk("R7", "wireless on", int'(wireless), 2);

    // R12: random throttle in S0
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      r = 1'($urandom);
      throttleReq = r;
      step(1);
      chk("R12", "throttle follows in S0", int'(throttleOut), int'(expThr(r)));
    end

    // R10: warm reset width, retrigger ignored
    @(negedge clk); warmRstReq = 1'b1;
    step(1);
    chk("R10", "warm reset asserts", int'(sysRstN), 0);
    @(negedge clk); warmRstReq = 1'b0;
    w = 1;
    while (!sysRstN && w < 300) begin
      if (w == 60) begin
        @(negedge clk); warmRstReq = 1'b1;
        step(1);
        @(negedge clk); warmRstReq = 1'b0;
      end else begin
        step(1);
      end
      w++;
    end
    chkRange("R10", "warm reset width", w, (RSTW - 1) * DIV + 1, RSTW * DIV);

    // R4/R6/R7: walk down
    @(negedge clk); slpS3n = 1'b0;
    walk(S_S0S3, S_S3, 2, "R4");
    chk("R7", "wireless suspended", int'(wireless), 1);
    hold = throttleOut;
    @(negedge clk); throttleReq = ~throttleReq;
    step(3);
    chk("R12", "throttle holds outside S0", int'(throttleOut), int'(hold));
    @(negedge clk); slpS5n = 1'b0;
    walk(S_S3S5, S_S5, 3, "R4");
    chk("R7", "wireless off", int'(wireless), 0);

    // R11: forced shutdown from S3
    @(negedge clk); slpS5n = 1'b1;
    walk(S_S5S3, S_S3, 0, "R4");
    @(negedge clk); forceOffReq = 1'b1;
    step(1);
    chk("R11", "power button asserted", int'(pwrBtnReq), 1);
    @(negedge clk); forceOffReq = 1'b0;
    step(5);
    chk("R11", "power button held", int'(pwrBtnReq), 1);
    @(negedge clk); slpS5n = 1'b0;
    step(4);
    chk("R11", "reached S5", int'(pwrState), S_S5);
    chk("R11", "button held on S5 entry", int'(pwrBtnReq), 1);
    step(1);
    chk("R11", "button released after S5", int'(pwrBtnReq), 0);

    // R5: standby loss from S3
    @(negedge clk); slpS5n = 1'b1;
    walk(S_S5S3, S_S3, 0, "R4");
    @(negedge clk); stbyGood = 1'b0;
    step(3);
    chk("R5", "standby loss to S5toG3", int'(pwrState), S_S5G3);
    chk("R8", "resume reset drops", int'(rsmRstN), 0);
    chk("R9", "power-OK falls", int'(socPwrOk), 0);
    step(1);
    chk("R5", "teardown reaches G3", int'(pwrState), S_G3);
    chk("R5", "rail dropped", int'(railEn), 0);
    @(negedge clk); warmRstReq = 1'b1;
    step(1);
    @(negedge clk); warmRstReq = 1'b0;
    chk("R10", "warm reset ignored in G3", int'(sysRstN), 1);

    // R1: warm start variants
    doReset(1'b1, 1'b1, 1'b1, S_S0, 1);
    doReset(1'b1, 1'b1, 1'b0, S_G3, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule